// File: doc/BRIEF.md
# Path Signal Label Monitor

This block watches the 3-bit signal label carried in the low-order path overhead, one sample per multiframe, and decides which label the path is really carrying. A sample is taken on every cycle where `lbl_vld` is high; a label becomes the accepted label only once it has been seen on a programmable number of consecutive samples. The accepted label is then judged in two ways. An accepted all-zero label marks the path as unequipped. Any other accepted label is compared with a programmed expected label, and a difference marks a payload label mismatch.

Each of the two defects has a sticky change-of-state delta bit and a mask. The block raises one combined interrupt from the unmasked delta bits. The unequipped flag is also driven out on its own so that an automatic AIS generator elsewhere can use it. Frame parsing, which produces the label samples, and the AIS generator are outside this block.

The acceptance filter is a three-state machine. `ST_EMPTY` is the state after reset, before any sample has arrived. `ST_TRACK` is the state while a candidate label is being counted but has not yet been accepted. `ST_MATCH` is the state once the candidate has been accepted. The transitions are as follows. On a sample that completes the run, `ST_EMPTY` and `ST_TRACK` go to `ST_MATCH`. On any other sample, `ST_EMPTY` goes to `ST_TRACK`. In `ST_TRACK`, a sample that does not complete the run keeps the machine in `ST_TRACK`. In `ST_MATCH`, a sample equal to the candidate stays in `ST_MATCH`. A differing sample moves the machine from `ST_MATCH` to `ST_TRACK`, or straight back to `ST_MATCH` when the run length is one.

Top module: `slm_label_mon`

## Requirements
- R1: After reset, `acc_lbl` is 000 and `uneq`, `plm`, `uneq_dlt`, `plm_dlt` and `irq` are all 0.
- R2: A label is accepted when it has been sampled on `persist_n` consecutive samples (a `persist_n` of 0 acts as 1). `acc_lbl` takes the new value at the clock edge that samples the final occurrence. Cycles with `lbl_vld` low neither count nor break a run.
- R3: A sample that differs from the current candidate restarts the count at one. With fewer than `persist_n` consecutive samples, `acc_lbl` keeps its value.
- R4: `uneq` is 1 from the cycle after an all-zero label is accepted, and it clears one cycle after a non-zero label is accepted.
- R5: `plm` is 1 one cycle after the accepted label differs from `exp_lbl`. When `exp_lbl` is 001, `plm` stays 0.
- R6: `plm` stays 0 while the unequipped condition holds.
- R7: A change of `uneq` sets `uneq_dlt`, and a change of `plm` sets `plm_dlt`, one cycle later. Both bits stay set until cleared through `dlt_clr`, where bit 0 clears `uneq_dlt` and bit 1 clears `plm_dlt`.
- R8: `irq` is the OR of `uneq_dlt & ~uneq_mask` and `plm_dlt & ~plm_mask`.
- R9: Before the first label is accepted after reset, `uneq` is 0, even though `acc_lbl` reads 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lbl_vld | input | 1 | Label sample strobe, one per multiframe |
| lbl_in | input | 3 | Received label sample |
| persist_n | input | 4 | Consecutive samples needed for acceptance |
| exp_lbl | input | 3 | Expected label |
| uneq_mask | input | 1 | Masks the unequipped delta from the interrupt |
| plm_mask | input | 1 | Masks the mismatch delta from the interrupt |
| dlt_clr | input | 2 | Delta clear pulses: bit 0 unequipped, bit 1 mismatch |
| acc_lbl | output | 3 | Accepted label |
| uneq | output | 1 | Unequipped defect, also feeds automatic AIS |
| plm | output | 1 | Payload label mismatch defect |
| uneq_dlt | output | 1 | Sticky change flag for `uneq` |
| plm_dlt | output | 1 | Sticky change flag for `plm` |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle. The accepted label never moves on a cycle without a sample. Mismatch and unequipped are never both raised. Mismatch is never raised after a cycle in which the expected label was 001. Unequipped follows an all-zero accepted label. Every change of a defect is followed by its delta bit. Only the bench scenarios can show how many samples acceptance takes and how that count restarts. They also cover the effect of a run length of zero, idle gaps inside a run, masking and clearing, and the reset-time rule that a 000 reading is not yet unequipped.

// File: rtl/slm_pkg.sv
package slm_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_TRACK = 2'd1,
        ST_MATCH = 2'd2
    } slm_state_e;

    localparam int DEF_UNEQ = 0;
    localparam int DEF_PLM  = 1;
    localparam int NUM_DEF  = 2;
endpackage

// File: rtl/slm_persist.sv
module slm_persist
    import slm_pkg::*;
#(
    parameter int LBL_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld,
    input  logic [LBL_W-1:0] lbl,
    input  logic [CNT_W-1:0] need,
    output logic [LBL_W-1:0] acc,
    output logic             acc_vld
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    slm_state_e       state_q, state_nx;
    logic [LBL_W-1:0] cand_q;
    logic [CNT_W-1:0] cnt_q, cnt_nx, eff_need;
    logic             same, hit;

    always_comb begin
        eff_need = (need == '0) ? CNT_ONE : need;
        same     = (state_q != ST_EMPTY) && (lbl == cand_q);
        if (same)
            cnt_nx = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
        else
            cnt_nx = CNT_ONE;
        hit = vld && (cnt_nx >= eff_need);
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_EMPTY: if (vld) state_nx = hit ? ST_MATCH : ST_TRACK;
            ST_TRACK: if (vld) state_nx = hit ? ST_MATCH : ST_TRACK;
            ST_MATCH: if (vld) state_nx = hit ? ST_MATCH : ST_TRACK;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q  <= '0;
            cnt_q   <= '0;
            acc     <= '0;
            acc_vld <= 1'b0;
        end else if (vld) begin
            cand_q <= lbl;
            cnt_q  <= cnt_nx;
            if (hit) begin
                acc     <= lbl;
                acc_vld <= 1'b1;
            end
        end
    end

    AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(acc)); // R2
endmodule

// File: rtl/slm_defect.sv
module slm_defect #(
    parameter int LBL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LBL_W-1:0] acc,
    input  logic             acc_vld,
    input  logic [LBL_W-1:0] exp_lbl,
    output logic             uneq_q,
    output logic             plm_q
);
    localparam logic [LBL_W-1:0] LBL_NOCHK = LBL_W'(1);

    logic uneq_nx, plm_nx;

    always_comb begin
        uneq_nx = acc_vld && (acc == '0);
        plm_nx  = acc_vld && !uneq_nx && (exp_lbl != LBL_NOCHK) && (acc != exp_lbl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uneq_q <= 1'b0;
            plm_q  <= 1'b0;
        end else begin
            uneq_q <= uneq_nx;
            plm_q  <= plm_nx;
        end
    end

    AST_PLM_NOT_UNEQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(uneq_q && plm_q)); // R6
    AST_PLM_OFF_EXP001: assert property (@(posedge clk) disable iff (!rst_n)
        (exp_lbl == LBL_NOCHK) |=> !plm_q); // R5
    AST_UNEQ_ZERO_LBL: assert property (@(posedge clk) disable iff (!rst_n)
        uneq_q |-> ($past(acc) == '0)); // R4
endmodule

// File: rtl/slm_delta.sv
module slm_delta #(
    parameter int N_DEF = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEF-1:0] def_in,
    input  logic [N_DEF-1:0] mask,
    input  logic [N_DEF-1:0] clr,
    output logic [N_DEF-1:0] dlt,
    output logic             irq
);
    for (genvar i = 0; i < N_DEF; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                dlt[i] <= 1'b0;
            end else begin
                prev_q <= def_in[i];
                if (prev_q != def_in[i]) dlt[i] <= 1'b1;
                else if (clr[i])         dlt[i] <= 1'b0;
            end
        end

        AST_DLT_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            (def_in[i] != $past(def_in[i])) |=> dlt[i]); // R7
    end

    always_comb irq = |(dlt & ~mask);
endmodule

// File: rtl/slm_label_mon.sv
module slm_label_mon
    import slm_pkg::*;
#(
    parameter int LBL_W = 3,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lbl_vld,
    input  logic [LBL_W-1:0] lbl_in,
    input  logic [CNT_W-1:0] persist_n,
    input  logic [LBL_W-1:0] exp_lbl,
    input  logic             uneq_mask,
    input  logic             plm_mask,
    input  logic [1:0]       dlt_clr,
    output logic [LBL_W-1:0] acc_lbl,
    output logic             uneq,
    output logic             plm,
    output logic             uneq_dlt,
    output logic             plm_dlt,
    output logic             irq
);
    logic               acc_vld;
    logic [NUM_DEF-1:0] def_vec, mask_vec, dlt_vec;

    slm_persist #(.LBL_W(LBL_W), .CNT_W(CNT_W)) u_persist (
        .clk(clk), .rst_n(rst_n), .vld(lbl_vld), .lbl(lbl_in),
        .need(persist_n), .acc(acc_lbl), .acc_vld(acc_vld)
    );

    slm_defect #(.LBL_W(LBL_W)) u_defect (
        .clk(clk), .rst_n(rst_n), .acc(acc_lbl), .acc_vld(acc_vld),
        .exp_lbl(exp_lbl), .uneq_q(uneq), .plm_q(plm)
    );

    always_comb begin
        def_vec            = '0;
        mask_vec           = '0;
        def_vec[DEF_UNEQ]  = uneq;
        def_vec[DEF_PLM]   = plm;
        mask_vec[DEF_UNEQ] = uneq_mask;
        mask_vec[DEF_PLM]  = plm_mask;
        uneq_dlt           = dlt_vec[DEF_UNEQ];
        plm_dlt            = dlt_vec[DEF_PLM];
    end

    slm_delta #(.N_DEF(NUM_DEF)) u_delta (
        .clk(clk), .rst_n(rst_n), .def_in(def_vec), .mask(mask_vec),
        .clr(dlt_clr), .dlt(dlt_vec), .irq(irq)
    );

    AST_UNEQ_NEEDS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        uneq |-> acc_vld); // R9
endmodule

// File: tb/slm_label_mon_tb_top.sv
module slm_label_mon_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lbl_vld = 1'b0;
    logic [2:0] lbl_in = '0;
    logic [3:0] persist_n = 4'd3;
    logic [2:0] exp_lbl = 3'd5;
    logic       uneq_mask = 1'b0;
    logic       plm_mask = 1'b0;
    logic [1:0] dlt_clr = '0;
    logic [2:0] acc_lbl;
    logic       uneq, plm, uneq_dlt, plm_dlt, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    slm_label_mon dut_i (
        .clk(clk), .rst_n(rst_n), .lbl_vld(lbl_vld), .lbl_in(lbl_in),
        .persist_n(persist_n), .exp_lbl(exp_lbl), .uneq_mask(uneq_mask),
        .plm_mask(plm_mask), .dlt_clr(dlt_clr), .acc_lbl(acc_lbl),
        .uneq(uneq), .plm(plm), .uneq_dlt(uneq_dlt), .plm_dlt(plm_dlt), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [2:0] v);
        @(negedge clk);
        lbl_vld = 1'b1;
        lbl_in  = v;
        @(negedge clk);
        lbl_vld = 1'b0;
    endtask

    task automatic clear(input logic [1:0] b);
        @(negedge clk);
        dlt_clr = b;
        @(negedge clk);
        dlt_clr = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 acc", acc_lbl, 0);
        check("R1 uneq", uneq, 0);
        check("R1 plm", plm, 0);
        check("R1 dlt", {uneq_dlt, plm_dlt}, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_accept();
        send(3'd5); send(3'd5);
        check("R3 two of three", acc_lbl, 0);
        send(3'd5);
        check("R2 accepted", acc_lbl, 5);
        idle(3);
        check("R5 match no plm", plm, 0);
        check("R4 nonzero no uneq", uneq, 0);
    endtask

    task automatic t_break();
        send(3'd2); send(3'd2); send(3'd7); send(3'd2); send(3'd2);
        check("R3 restart", acc_lbl, 5);
        send(3'd2);
        check("R2 after restart", acc_lbl, 2);
        idle(3);
        check("R5 mismatch", plm, 1);
        check("R7 plm delta", plm_dlt, 1);
        check("R8 irq", irq, 1);
        plm_mask = 1'b1;
        idle(1);
        check("R8 masked", irq, 0);
        plm_mask = 1'b0;
        clear(2'b10);
        check("R7 cleared", plm_dlt, 0);
        check("R8 irq after clear", irq, 0);
    endtask

    task automatic t_uneq();
        send(3'd0); send(3'd0); send(3'd0);
        idle(3);
        check("R4 uneq set", uneq, 1);
        check("R6 plm off", plm, 0);
        check("R7 uneq delta", uneq_dlt, 1);
        check("R7 plm delta fall", plm_dlt, 1);
        clear(2'b11);
        check("R7 both cleared", {uneq_dlt, plm_dlt}, 0);
    endtask

    task automatic t_exp001();
        exp_lbl = 3'd1;
        send(3'd4); send(3'd4); send(3'd4);
        idle(3);
        check("R4 uneq clear", uneq, 0);
        check("R5 exp001 no plm", plm, 0);
        exp_lbl = 3'd6;
        idle(3);
        check("R5 plm after exp change", plm, 1);
        clear(2'b11);
    endtask

    task automatic t_n0_gap();
        persist_n = 4'd0;
        send(3'd3);
        check("R2 n0 acts as one", acc_lbl, 3);
        persist_n = 4'd2;
        send(3'd1);
        idle(5);
        check("R2 gap no accept yet", acc_lbl, 3);
        send(3'd1);
        check("R2 gap keeps run", acc_lbl, 1);
    endtask

    task automatic t_first_zero();
        do_reset();
        check("R9 no uneq before accept", uneq, 0);
        persist_n = 4'd1;
        send(3'd0);
        idle(3);
        check("R4 first accept zero", uneq, 1);
        uneq_mask = 1'b1;
        idle(1);
        check("R8 uneq masked", irq, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_accept();
                t_break();
                t_uneq();
                t_exp001();
                t_n0_gap();
                t_first_zero();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule